// File: doc/BRIEF.md
# Recency-Position Dead-Line Profiler

This block sits beside a set-associative last-level cache. It watches every cache request and counts hits by their position in the recency stack of the set that hit. Position 0 is the most recently used way and position WAYS-1 the least recently used. It also counts misses. The counters are shared by all sets. At the end of every sampling window of `PERIOD` cycles it computes a cutoff position. Stack positions from the cutoff to the bottom of the stack together earned too few hits to matter, so they count as dead until the next window closes. All counters then clear.

On any cycle when the cache reports idle and the eager write-back queue is not full, the block draws a pseudo-random set index from an internal LFSR and drives it on the lookup port. The cache answers in the same cycle with that set's dirty bits and the recency position of each way. If any dirty way sits at or below the cutoff, the deepest of them is offered on a valid/ready candidate stream as a set and way pair. When the cache accepts the candidate, it writes the line back slowly, marks it clean and keeps it resident.

The candidate stream obeys valid/ready rules. Once `cand_valid` is high, it stays high with `cand_set` and `cand_way` unchanged until `cand_ready` is seen high at a clock edge. A new lookup is allowed only when the output slot is empty or is being emptied on that same edge.

Top module: `stackpos_wb_profiler`

## Requirements
- R1: After reset, `cutoff` equals WAYS and `cand_valid` is low.
- R2: Each cycle with `req_valid` high adds one to the hit counter of `req_pos` when `req_hit` is high, and to the miss counter otherwise. Every counter restarts from zero after each window closes, so requests from one window never affect the cutoff of a later one.
- R3: A window is the span of PERIOD rising edges starting with the first edge after reset, and each later window follows directly. A request on the last edge of a window counts toward that window. On that edge `cutoff` takes the lowest position p whose hits summed over p..WAYS-1 are strictly less than (hits+misses) shifted right by five bits. Between window ends, `cutoff` does not change.
- R4: If no position meets the R3 test, including the case where the shifted total is zero, `cutoff` becomes WAYS.
- R5: A lookup happens only on an edge where `cache_idle` is high, `evq_full` is low, and `cand_valid` is low or `cand_ready` is high. On other edges where `cand_ready` empties the slot, `cand_valid` goes low.
- R6: On a lookup edge, the way that is offered is the dirty way (bit w of `lk_dirty`) whose position (`lk_rank[w*POS_W +: POS_W]`) is the largest among dirty ways with position >= `cutoff`. `cand_set` is the `lk_set` of that cycle. If no dirty way qualifies, `cand_valid` goes low.
- R7: While `cand_valid` is high and `cand_ready` is low, `cand_valid`, `cand_set` and `cand_way` stay unchanged. An accepted candidate is marked clean by the cache and stays resident.
- R8: A lookup made in a cycle is reflected on the candidate outputs right after that cycle's rising edge.
- R9: While `cutoff` equals WAYS, no lookup produces a candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A cache request occurs this cycle |
| req_hit | input | 1 | The request hit |
| req_pos | input | POS_W | Recency position of the hit way |
| cache_idle | input | 1 | The cache has a free cycle |
| evq_full | input | 1 | The eager write-back queue cannot take more |
| lk_set | output | SET_W | Set index being looked up |
| lk_dirty | input | WAYS | Dirty bit per way of the looked-up set |
| lk_rank | input | WAYS*POS_W | Recency position per way, way w in bits [w*POS_W +: POS_W] |
| cutoff | output | CUT_W | First dead recency position; WAYS means none |
| cand_valid | output | 1 | A write-back candidate is offered |
| cand_ready | input | 1 | The cache accepts the candidate |
| cand_set | output | SET_W | Set of the candidate line |
| cand_way | output | POS_W | Way of the candidate line |

## Verification
A new cutoff appears on the last rising edge of a PERIOD-cycle window. The bench therefore drives each window as exactly PERIOD cycles from a known start and reads `cutoff` at the falling edge after that last edge. It compares the value against a cutoff computed arithmetically from the hit and miss counts it issued. Candidate results are due one edge after the lookup cycle. In each cycle the bench records the `lk_set` it sees and the slot state, predicts the candidate from its own set-to-dirty/rank model, and compares at the next falling edge. Windows sweep hit distributions on both sides of the 1/32 threshold, an exact-equality case and an all-miss window. Candidate phases run under free flow, a full eager queue, toggling back-pressure and a no-dead-position cutoff.

// File: rtl/dlp_pkg.sv
package dlp_pkg;
  localparam int unsigned LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return s[0] ? ((s >> 1) ^ LFSR_TAPS) : (s >> 1);
  endfunction
endpackage

// File: rtl/dlp_lfsr.sv
module dlp_lfsr #(
  parameter int unsigned OUT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [OUT_W-1:0] value
);
  import dlp_pkg::*;

  logic [LFSR_W-1:0] state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LFSR_SEED;
    else if (adv) state_q <= lfsr_step(state_q);
  end

  // Fold every state bit into the output so all of them spread the set index.
  always_comb begin
    value = '0;
    for (int i = 0; i < int'(LFSR_W); i++) begin
      value[i % OUT_W] = value[i % OUT_W] ^ state_q[i];
    end
  end
endmodule

// File: rtl/dlp_hit_profiler.sv
module dlp_hit_profiler #(
  parameter int unsigned WAYS      = 16,
  parameter int unsigned PERIOD    = 1000000,
  parameter int unsigned THR_SHIFT = 5,
  localparam int unsigned POS_W    = $clog2(WAYS),
  localparam int unsigned CNT_W    = $clog2(PERIOD + 1),
  localparam int unsigned CUT_W    = $clog2(WAYS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_hit,
  input  logic [POS_W-1:0] req_pos,
  output logic [CUT_W-1:0] cutoff
);
  logic [CNT_W-1:0] hit_q  [WAYS];
  logic [CNT_W-1:0] hit_nx [WAYS];
  logic [CNT_W-1:0] miss_q, miss_nx, cyc_q;
  logic [CNT_W-1:0] total, thr, suffix;
  logic [CUT_W-1:0] dead_cnt, cut_nx;
  logic             period_end;

  assign period_end = (cyc_q == CNT_W'(PERIOD - 1));
  assign miss_nx    = miss_q + CNT_W'(req_valid && !req_hit);

  for (genvar i = 0; i < int'(WAYS); i++) begin : g_pos
    assign hit_nx[i] = hit_q[i] + CNT_W'(req_valid && req_hit && (req_pos == POS_W'(i)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          hit_q[i] <= '0;
      else if (period_end) hit_q[i] <= '0;
      else                 hit_q[i] <= hit_nx[i];
    end
  end

  // Positions whose tail sum falls under the threshold form a contiguous
  // bottom run of the stack, so counting them gives the cutoff directly.
  always_comb begin
    total = miss_nx;
    for (int i = 0; i < int'(WAYS); i++) total = total + hit_nx[i];
    thr      = total >> THR_SHIFT;
    suffix   = '0;
    dead_cnt = '0;
    for (int p = int'(WAYS) - 1; p >= 0; p--) begin
      suffix = suffix + hit_nx[p];
      if (suffix < thr) dead_cnt = dead_cnt + CUT_W'(1);
    end
    cut_nx = CUT_W'(WAYS) - dead_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miss_q <= '0;
      cyc_q  <= '0;
      cutoff <= CUT_W'(WAYS);
    end else if (period_end) begin
      miss_q <= '0;
      cyc_q  <= '0;
      cutoff <= cut_nx;
    end else begin
      miss_q <= miss_nx;
      cyc_q  <= cyc_q + CNT_W'(1);
    end
  end

  assert_window_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_q < CNT_W'(PERIOD));
  assert_cutoff_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> $stable(cutoff));
  assert_counts_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> (miss_q == '0 && cyc_q == '0));
  assert_cutoff_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cutoff <= CUT_W'(WAYS));
endmodule

// File: rtl/dlp_victim_pick.sv
module dlp_victim_pick #(
  parameter int unsigned WAYS   = 16,
  localparam int unsigned POS_W = $clog2(WAYS),
  localparam int unsigned CUT_W = $clog2(WAYS + 1)
) (
  input  logic [WAYS-1:0]       dirty,
  input  logic [WAYS*POS_W-1:0] rank,
  input  logic [CUT_W-1:0]      cutoff,
  output logic                  found,
  output logic [POS_W-1:0]      way
);
  logic [POS_W-1:0] best, r;

  always_comb begin
    found = 1'b0;
    way   = '0;
    best  = '0;
    r     = '0;
    for (int w = 0; w < int'(WAYS); w++) begin
      r = rank[w*POS_W +: POS_W];
      if (dirty[w] && (CUT_W'(r) >= cutoff) && (!found || r > best)) begin
        found = 1'b1;
        best  = r;
        way   = POS_W'(w);
      end
    end
  end
endmodule

// File: rtl/stackpos_wb_profiler.sv
module stackpos_wb_profiler #(
  parameter int unsigned WAYS      = 16,
  parameter int unsigned SETS      = 1024,
  parameter int unsigned PERIOD    = 1000000,
  parameter int unsigned THR_SHIFT = 5,
  localparam int unsigned POS_W    = $clog2(WAYS),
  localparam int unsigned SET_W    = $clog2(SETS),
  localparam int unsigned CUT_W    = $clog2(WAYS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_hit,
  input  logic [POS_W-1:0]      req_pos,
  input  logic                  cache_idle,
  input  logic                  evq_full,
  output logic [SET_W-1:0]      lk_set,
  input  logic [WAYS-1:0]       lk_dirty,
  input  logic [WAYS*POS_W-1:0] lk_rank,
  output logic [CUT_W-1:0]      cutoff,
  output logic                  cand_valid,
  input  logic                  cand_ready,
  output logic [SET_W-1:0]      cand_set,
  output logic [POS_W-1:0]      cand_way
);
  logic             slot_free, attempt, pick_found;
  logic [POS_W-1:0] pick_way;

  assign slot_free = !cand_valid || cand_ready;
  assign attempt   = cache_idle && !evq_full && slot_free;

  dlp_hit_profiler #(.WAYS(WAYS), .PERIOD(PERIOD), .THR_SHIFT(THR_SHIFT)) u_prof (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_hit(req_hit),
    .req_pos(req_pos), .cutoff(cutoff));

  dlp_lfsr #(.OUT_W(SET_W)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .adv(attempt), .value(lk_set));

  dlp_victim_pick #(.WAYS(WAYS)) u_pick (
    .dirty(lk_dirty), .rank(lk_rank), .cutoff(cutoff),
    .found(pick_found), .way(pick_way));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_valid <= 1'b0;
      cand_set   <= '0;
      cand_way   <= '0;
    end else if (attempt) begin
      cand_valid <= pick_found;
      if (pick_found) begin
        cand_set <= lk_set;
        cand_way <= pick_way;
      end
    end else if (cand_ready) begin
      cand_valid <= 1'b0;
    end
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid && !cand_ready |=> cand_valid && $stable(cand_set) && $stable(cand_way));
  assert_no_lookup_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cache_idle || evq_full) && !cand_valid |=> !cand_valid);
  assert_pick_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    attempt && pick_found |-> lk_dirty[pick_way]
      && (CUT_W'(lk_rank[pick_way*POS_W +: POS_W]) >= cutoff));
  assert_none_when_full_cut_R9: assert property (@(posedge clk) disable iff (!rst_n)
    attempt && (cutoff == CUT_W'(WAYS)) |=> !cand_valid);
endmodule

// File: tb/stackpos_wb_profiler_bench.sv
module stackpos_wb_profiler_bench;
  localparam int WAYS = 4, SETS = 8, PERIOD = 64;
  localparam int POS_W = 2, SET_W = 3, CUT_W = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_hit = 0, cache_idle = 0, evq_full = 0, cand_ready = 1;
  logic [POS_W-1:0] req_pos = '0;
  logic [SET_W-1:0] lk_set, cand_set;
  logic [WAYS-1:0] lk_dirty;
  logic [WAYS*POS_W-1:0] lk_rank;
  logic [CUT_W-1:0] cutoff;
  logic cand_valid;
  logic [POS_W-1:0] cand_way;

  int n_chk = 0, n_bad = 0, cur_cut = WAYS;
  bit done = 0;

  always #2.5 clk = ~clk;

  stackpos_wb_profiler #(.WAYS(WAYS), .SETS(SETS), .PERIOD(PERIOD)) u_stackpos_wb_profiler (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_hit(req_hit), .req_pos(req_pos),
    .cache_idle(cache_idle), .evq_full(evq_full), .lk_set(lk_set), .lk_dirty(lk_dirty),
    .lk_rank(lk_rank), .cutoff(cutoff), .cand_valid(cand_valid), .cand_ready(cand_ready),
    .cand_set(cand_set), .cand_way(cand_way));

  // Cache model: way w of set s sits at position (w+s)%4; dirty mask from s.
  function automatic int rank_of(int s, int w); return (w + s) % WAYS; endfunction
  function automatic int dirty_of(int s); return ((1 << (s % WAYS)) | (s * 3)) & 15; endfunction

  always_comb begin
    lk_dirty = WAYS'(dirty_of(int'(lk_set)));
    for (int w = 0; w < WAYS; w++) lk_rank[w*POS_W +: POS_W] = POS_W'(rank_of(int'(lk_set), w));
  end

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int exp_cutoff(int h0, int h1, int h2, int h3, int m);
    int h[4];
    int thr, suf, cut;
    h[0] = h0; h[1] = h1; h[2] = h2; h[3] = h3;
    thr = (h0 + h1 + h2 + h3 + m) >> 5;
    suf = 0; cut = WAYS;
    for (int p = WAYS - 1; p >= 0; p--) begin
      suf += h[p];
      if (suf < thr) cut = p;
    end
    return cut;
  endfunction

  // mode: 0 busy cache, 1 free flow, 2 eager queue full, 3 toggling back-pressure
  task automatic run_period(int h0, int h1, int h2, int h3, int m, int mode);
    int hsum, ls, found, way, best, ev, es, ew, v0, s0, w0;
    bit take, att, chk_sw;
    string tag;
    hsum = h0 + h1 + h2 + h3;
    for (int c = 0; c < PERIOD; c++) begin
      req_valid = (c < hsum + m);
      req_hit   = (c < hsum);
      req_pos   = (c < h0) ? 2'd0 : (c < h0 + h1) ? 2'd1 : (c < h0 + h1 + h2) ? 2'd2 : 2'd3;
      cache_idle = (mode != 0) && (c >= hsum + m);
      evq_full   = (mode == 2);
      cand_ready = (mode == 3) ? c[1] : 1'b1;
      v0 = cand_valid; s0 = cand_set; w0 = cand_way; ls = lk_set;
      take = !v0 || cand_ready;
      att  = cache_idle && !evq_full && take;
      chk_sw = 0; ev = 0; es = 0; ew = 0;
      if (att) begin
        found = 0; way = 0; best = 0;
        for (int w = 0; w < WAYS; w++) begin
          if (dirty_of(ls)[w] && rank_of(ls, w) >= cur_cut && (!found || rank_of(ls, w) > best)) begin
            found = 1; best = rank_of(ls, w); way = w;
          end
        end
        ev = found; es = ls; ew = way; chk_sw = found;
        tag = (cur_cut == WAYS) ? "R9" : "R6/R8";
      end else if (take) begin
        tag = "R5";
      end else begin
        ev = 1; es = s0; ew = w0; chk_sw = 1; tag = "R7";
      end
      @(negedge clk);
      chk(int'(cand_valid) == ev, tag, "cand_valid", int'(cand_valid), ev);
      if (chk_sw) begin
        chk(int'(cand_set) == es, tag, "cand_set", int'(cand_set), es);
        chk(int'(cand_way) == ew, tag, "cand_way", int'(cand_way), ew);
      end
    end
    cur_cut = exp_cutoff(h0, h1, h2, h3, m);
    chk(int'(cutoff) == cur_cut, "R2/R3/R4", "cutoff", int'(cutoff), cur_cut);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(int'(cutoff) == WAYS, "R1", "reset cutoff", int'(cutoff), WAYS);
    chk(cand_valid == 1'b0, "R1", "reset cand_valid", int'(cand_valid), 0);
    rst_n = 1'b1;
    run_period(40, 10, 1, 0, 13, 0);   // R3: tail of 1 under 2 -> 2
    run_period(0, 0, 0, 0, 0, 1);      // R6 lookups at cut 2; R2 cleared -> R4 gives 4
    run_period(0, 0, 0, 0, 0, 1);      // R9 at cut 4
    run_period(0, 0, 0, 0, 64, 0);     // all misses -> 0
    run_period(0, 0, 0, 0, 0, 3);      // R7 back-pressure at cut 0
    run_period(30, 20, 2, 1, 11, 0);   // -> 3
    run_period(0, 0, 0, 0, 0, 2);      // R5 queue full
    run_period(50, 5, 2, 0, 7, 0);     // tail equal to threshold -> 3
    run_period(60, 3, 0, 0, 0, 0);     // total 63, threshold 1 -> 2
    run_period(0, 0, 0, 0, 0, 1);      // R6 at cut 2
    for (int t = 0; t < 5; t++) run_period(60 - t, 0, 0, t, 4, 0);
    run_period(20, 20, 20, 4, 0, 1);   // mixed: requests then lookups at cut from sweep
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule